// File: doc/BRIEF.md
# Banked Hub Memory Slot Arbiter

This block shares four memory banks among 32 processor cores. Cores are numbered 0 to 31; the number splits into a 2-bit group (bits 4:3) and a 3-bit slot index (bits 2:0). Each group of eight cores owns one bank. A slot counter steps through the eight slot indices, one per clock. In each cycle only the four cores whose slot index matches the current slot can be served, so up to four banks work in parallel.

Any core can be marked "full". A full core treats the four banks as one contiguous space: the top two bits of its address choose the bank. Only one core per slot index may be full. When the full core of the current slot requests, it alone is served. When it is idle, the other three cores of that slot each use their own bank. Only core 0, the boot core, may change the full marks. An attempt to mark a second full core on a slot index that is already taken is refused and raises a sticky error flag.

A core holds its request until it sees its grant. Read data comes back on that core's read port one cycle after the grant. The banks are modelled as synchronous single-port arrays. Their sizes are set by package constants; a core's address carries BANK_AW offset bits plus two bank bits.

Top module: `hub_slot_arbiter`

## Requirements
- R1: The slot counter is 0 after reset and advances by one each clock, wrapping 7 to 0. A core can be granted only in cycles where its slot index (ID bits 2:0) equals the counter.
- R2: While reset is high and right after it, no grants are given, all read data is zero, no core is full and the error flag is clear.
- R3: A configuration write (cfg_valid high) changes the full marks only when cfg_src is 0. Writes from any other source change neither the marks nor the error flag.
- R4: A write from core 0 that sets core X full while another core with X's slot index is already full is ignored and sets cfg_err, which stays set until reset. Clearing a mark is always accepted. After a mark is cleared, a different core of that slot index may be set.
- R5: When the full core of the current slot requests, it is the only core granted in that cycle.
- R6: When the full core of the current slot does not request, each requesting core of that slot is granted on its own group's bank in the same cycle.
- R7: A full core reaches bank addr[BANK_AW+1:BANK_AW] at offset addr[BANK_AW-1:0]. Data written there is read back by a local core of that bank's group at the same offset.
- R8: A core that is not full always uses its own group's bank. Its top two address bits are ignored.
- R9: A granted read returns the word on the core's rdata field exactly one cycle after the grant. In every other cycle that field is zero.
- R10: No core is granted without a request. A core that is not granted keeps waiting, and it gets no grant in other slots.
- R11: Each grant drives exactly one bank port (bank_en high) with the granted core's write enable, offset and write data. An idle bank has bank_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 32 | Per-core access request |
| we | input | 32 | Per-core write enable (1 = write) |
| addr | input | 32*(BANK_AW+2) | Per-core address; core c uses field c |
| wdata | input | 32*DATA_W | Per-core write data |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_src | input | 5 | ID of the core issuing the configuration write |
| cfg_core | input | 5 | Core whose full mark is written |
| cfg_full | input | 1 | New full mark value |
| gnt | output | 32 | Per-core grant for this cycle |
| rdata | output | 32*DATA_W | Per-core read data, valid one cycle after a read grant |
| cfg_err | output | 1 | Sticky flag: refused second full core on a slot index |
| bank_en | output | 4 | Per-bank access enable |
| bank_we | output | 4 | Per-bank write enable |
| bank_addr | output | 4*BANK_AW | Per-bank word offset |
| bank_wdata | output | 4*DATA_W | Per-bank write data |

## Verification
If the slot counter goes wrong, grants appear in a slot that does not match the core's ID bits. This shows on gnt in the very cycle it happens. A corrupted full mark shows either as a core wrongly granted alone, or as a full-range write landing in the requester's own bank; the bank port shows this in the grant cycle, and a read-back from the other group shows it one cycle later. An error in the read-return registers gives wrong or non-zero rdata in the cycle after a grant. An error in the configuration guard shows on cfg_err, or on the bank a later access reaches, right after the configuration write.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
    localparam int GROUPS  = 4;
    localparam int SLOTS   = 8;
    localparam int GRP_W   = $clog2(GROUPS);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int CORES   = GROUPS * SLOTS;
    localparam int ID_W    = GRP_W + SLOT_W;
    localparam int BANK_AW = 8;
    localparam int FULL_AW = BANK_AW + GRP_W;
    localparam int DATA_W  = 32;

    typedef logic [ID_W-1:0] core_id_t;

    typedef struct packed {
        logic               en;
        logic               we;
        logic [BANK_AW-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } bank_cmd_t;

    function automatic core_id_t core_id(input int g, input logic [SLOT_W-1:0] s);
        logic [GRP_W-1:0] gb;
        gb = g[GRP_W-1:0];
        return {gb, s};
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input core_id_t id);
        return id[SLOT_W-1:0];
    endfunction
endpackage

// File: rtl/hub_slot_ring.sv
module hub_slot_ring
    import hub_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_o
);
    always_ff @(posedge clk) begin
        if (rst) slot_o <= '0;
        else     slot_o <= slot_o + 1'b1;
    end
endmodule

// File: rtl/hub_full_cfg.sv
module hub_full_cfg
    import hub_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  core_id_t         cfg_src,
    input  core_id_t         cfg_core,
    input  logic             cfg_full,
    output logic [CORES-1:0] full_o,
    output logic             err_o
);
    logic clash;
    logic accept;

    // Another core on the same slot index already holds the full mark
    always_comb begin
        core_id_t id;
        clash = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            id = core_id(g, slot_of(cfg_core));
            if (id != cfg_core && full_o[id]) clash = 1'b1;
        end
    end

    assign accept = cfg_valid && (cfg_src == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_o <= '0;
            err_o  <= 1'b0;
        end else if (accept) begin
            if (cfg_full && clash) err_o <= 1'b1;
            else                   full_o[cfg_core] <= cfg_full;
        end
    end
endmodule

// File: rtl/hub_bank_ram.sv
module hub_bank_ram
    import hub_arb_pkg::*;
(
    input  logic              clk,
    input  bank_cmd_t         cmd,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [2**BANK_AW];

    always_ff @(posedge clk) begin
        if (cmd.en) begin
            if (cmd.we) mem[cmd.addr] <= cmd.wdata;
            else        dout <= mem[cmd.addr];
        end
    end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
    import hub_arb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CORES-1:0]          req,
    input  logic [CORES-1:0]          we,
    input  logic [CORES*FULL_AW-1:0]  addr,
    input  logic [CORES*DATA_W-1:0]   wdata,
    input  logic                      cfg_valid,
    input  logic [ID_W-1:0]           cfg_src,
    input  logic [ID_W-1:0]           cfg_core,
    input  logic                      cfg_full,
    output logic [CORES-1:0]          gnt,
    output logic [CORES*DATA_W-1:0]   rdata,
    output logic                      cfg_err,
    output logic [GROUPS-1:0]         bank_en,
    output logic [GROUPS-1:0]         bank_we,
    output logic [GROUPS*BANK_AW-1:0] bank_addr,
    output logic [GROUPS*DATA_W-1:0]  bank_wdata
);
    logic [SLOT_W-1:0]  slot_q;
    logic [CORES-1:0]   full_q;
    logic [FULL_AW-1:0] addr_a  [CORES];
    logic [DATA_W-1:0]  wdata_a [CORES];
    bank_cmd_t          cmd     [GROUPS];
    logic [DATA_W-1:0]  dout    [GROUPS];
    logic [GRP_W-1:0]   tgt     [CORES];
    logic [GRP_W-1:0]   rbank_q [CORES];
    logic [CORES-1:0]   rd_q;

    hub_slot_ring u_ring (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot_q)
    );

    hub_full_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .cfg_src   (cfg_src),
        .cfg_core  (cfg_core),
        .cfg_full  (cfg_full),
        .full_o    (full_q),
        .err_o     (cfg_err)
    );

    for (genvar c = 0; c < CORES; c++) begin : g_core
        assign addr_a[c]  = addr[c*FULL_AW +: FULL_AW];
        assign wdata_a[c] = wdata[c*DATA_W +: DATA_W];
        assign rdata[c*DATA_W +: DATA_W] = rd_q[c] ? dout[rbank_q[c]] : '0;
    end

    // Slot arbitration: the full core of the slot wins outright, otherwise
    // each group's core in this slot goes to its own bank.
    always_comb begin
        core_id_t         id;
        core_id_t         full_c;
        logic             full_hit;
        logic [GRP_W-1:0] fb;
        gnt      = '0;
        full_hit = 1'b0;
        full_c   = '0;
        fb       = '0;
        for (int b = 0; b < GROUPS; b++) cmd[b] = '0;
        for (int c = 0; c < CORES; c++)  tgt[c] = '0;
        for (int g = 0; g < GROUPS; g++) begin
            id = core_id(g, slot_q);
            if (full_q[id]) begin
                full_hit = 1'b1;
                full_c   = id;
            end
        end
        if (full_hit && req[full_c]) begin
            fb                = addr_a[full_c][FULL_AW-1 -: GRP_W];
            gnt[full_c]       = 1'b1;
            tgt[full_c]       = fb;
            cmd[fb].en        = 1'b1;
            cmd[fb].we        = we[full_c];
            cmd[fb].addr      = addr_a[full_c][BANK_AW-1:0];
            cmd[fb].wdata     = wdata_a[full_c];
        end else begin
            for (int g = 0; g < GROUPS; g++) begin
                id = core_id(g, slot_q);
                if (req[id]) begin
                    gnt[id]      = 1'b1;
                    tgt[id]      = g[GRP_W-1:0];
                    cmd[g].en    = 1'b1;
                    cmd[g].we    = we[id];
                    cmd[g].addr  = addr_a[id][BANK_AW-1:0];
                    cmd[g].wdata = wdata_a[id];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= gnt & ~we;
        for (int c = 0; c < CORES; c++) rbank_q[c] <= tgt[c];
    end

    for (genvar b = 0; b < GROUPS; b++) begin : g_bank
        hub_bank_ram u_bank (
            .clk  (clk),
            .cmd  (cmd[b]),
            .dout (dout[b])
        );
        assign bank_en[b]                         = cmd[b].en;
        assign bank_we[b]                         = cmd[b].we;
        assign bank_addr[b*BANK_AW +: BANK_AW]    = cmd[b].addr;
        assign bank_wdata[b*DATA_W +: DATA_W]     = cmd[b].wdata;
    end
endmodule

// File: rtl/hub_slot_arbiter_chk.sv
module hub_slot_arbiter_chk
    import hub_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CORES-1:0]  req,
    input logic [CORES-1:0]  gnt,
    input logic [CORES-1:0]  full_q,
    input logic [SLOT_W-1:0] slot_q,
    input logic              cfg_valid,
    input logic [ID_W-1:0]   cfg_src,
    input logic              cfg_err,
    input logic [GROUPS-1:0] bank_en
);
    a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> slot_q == SLOT_W'($past(slot_q) + 1'b1));

    a_r3_src_guard: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_src != '0) |=> ($stable(full_q) && $stable(cfg_err)));

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [GROUPS-1:0] fs;
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign fs[g] = full_q[g*SLOTS + s];
        end
        a_r4_one_full: assert property (@(posedge clk) disable iff (rst)
            $countones(fs) <= 1);
    end

    a_r5_full_alone: assert property (@(posedge clk) disable iff (rst)
        ((gnt & full_q) != '0) |-> $countones(gnt) == 1);

    a_r10_need_req: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    a_r11_bank_per_grant: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt) == $countones(bank_en));
endmodule

bind hub_slot_arbiter hub_slot_arbiter_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .gnt       (gnt),
    .full_q    (full_q),
    .slot_q    (slot_q),
    .cfg_valid (cfg_valid),
    .cfg_src   (cfg_src),
    .cfg_err   (cfg_err),
    .bank_en   (bank_en)
);

// File: tb/hub_slot_arbiter_tb_top.sv
module hub_slot_arbiter_tb_top;
    import hub_arb_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [CORES-1:0]          req = '0;
    logic [CORES-1:0]          we = '0;
    logic [CORES*FULL_AW-1:0]  addr = '0;
    logic [CORES*DATA_W-1:0]   wdata = '0;
    logic                      cfg_valid = 1'b0;
    logic [ID_W-1:0]           cfg_src = '0;
    logic [ID_W-1:0]           cfg_core = '0;
    logic                      cfg_full = 1'b0;
    logic [CORES-1:0]          gnt;
    logic [CORES*DATA_W-1:0]   rdata;
    logic                      cfg_err;
    logic [GROUPS-1:0]         bank_en;
    logic [GROUPS-1:0]         bank_we;
    logic [GROUPS*BANK_AW-1:0] bank_addr;
    logic [GROUPS*DATA_W-1:0]  bank_wdata;

    hub_slot_arbiter dut_i (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef struct {
        int          core;
        int          due;
        logic [31:0] data;
    } exp_t;
    exp_t sbq[$];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data in the cycle it is due
    always @(posedge clk) begin
        #2;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            check_eq("R9 read data one cycle after grant",
                     64'(rdata[it.core*DATA_W +: DATA_W]), 64'(it.data));
        end
    end

    function automatic logic [FULL_AW-1:0] mk_addr(input int bank, input int off);
        return {bank[GRP_W-1:0], off[BANK_AW-1:0]};
    endfunction

    // Driver: holds a request until granted, checks slot and bank port
    task automatic access(input int c, input logic [FULL_AW-1:0] a, input bit w,
                          input logic [31:0] d, input logic [GROUPS-1:0] exp_bank);
        bit got;
        got = 1'b0;
        @(negedge clk);
        req[c] = 1'b1;
        we[c]  = w;
        addr[c*FULL_AW +: FULL_AW] = a;
        wdata[c*DATA_W +: DATA_W]  = w ? d : '0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (gnt[c]) begin
                got = 1'b1;
                check_eq("R1 grant only in own slot", 64'(cyc % SLOTS), 64'(c % SLOTS));
                check_eq("R11 bank port of grant", 64'(bank_en), 64'(exp_bank));
                if (!w) sbq.push_back('{c, cyc + 1, d});
                break;
            end
            @(negedge clk);
        end
        check_eq("R10 held request eventually granted", 64'(got), 64'd1);
        @(negedge clk);
        req[c] = 1'b0;
        we[c]  = 1'b0;
    endtask

    task automatic cfg_write(input int src, input int core, input bit f);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_src   = src[ID_W-1:0];
        cfg_core  = core[ID_W-1:0];
        cfg_full  = f;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_slot(input int s);
        @(negedge clk);
        while (cyc % SLOTS != s) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_eq("R2 no grant in reset", 64'(gnt), 64'd0);
        check_eq("R2 error clear in reset", 64'(cfg_err), 64'd0);
        check_eq("R2 rdata zero in reset", 64'(rdata == '0), 64'd1);
        rst = 1'b0;

        // Local write/read on group 0
        access(5, mk_addr(0, 3), 1'b1, 32'hA5A5_0005, 4'b0001);
        access(5, mk_addr(0, 3), 1'b0, 32'hA5A5_0005, 4'b0001);

        // R10: request waits through foreign slots
        access(13, mk_addr(0, 3), 1'b1, 32'h1313_1313, 4'b0010);
        wait_slot(6);
        req[13] = 1'b1;
        addr[13*FULL_AW +: FULL_AW] = mk_addr(0, 3);
        for (int i = 0; i < 7; i++) begin
            #1;
            check_eq("R10 no grant outside slot", 64'(gnt[13]), 64'd0);
            @(negedge clk);
        end
        #1;
        check_eq("R10 grant in own slot", 64'(gnt[13]), 64'd1);
        sbq.push_back('{13, cyc + 1, 32'h1313_1313});
        @(negedge clk);
        req[13] = 1'b0;

        // R3: non-boot source cannot set full
        cfg_write(3, 10, 1'b1);
        access(10, mk_addr(3, 7), 1'b1, 32'h0000_1111, 4'b0010);
        access(10, mk_addr(0, 7), 1'b0, 32'h0000_1111, 4'b0010);
        check_eq("R3 no error from foreign source", 64'(cfg_err), 64'd0);

        // R7: boot core marks core 10 full
        cfg_write(0, 10, 1'b1);
        access(10, mk_addr(3, 7), 1'b1, 32'hBEEF_0010, 4'b1000);
        access(26, mk_addr(0, 7), 1'b0, 32'hBEEF_0010, 4'b1000);
        access(10, mk_addr(1, 7), 1'b0, 32'h0000_1111, 4'b0010);

        // R4: second full on slot 2 refused
        cfg_write(0, 2, 1'b1);
        #1;
        check_eq("R4 error on claimed slot", 64'(cfg_err), 64'd1);
        access(2, mk_addr(3, 9), 1'b1, 32'h0000_0022, 4'b0001);

        // R5: full core requesting is served alone
        wait_slot(2);
        req = '0;
        req[2] = 1'b1; req[10] = 1'b1; req[18] = 1'b1; req[26] = 1'b1;
        addr[10*FULL_AW +: FULL_AW] = mk_addr(3, 4);
        #1;
        check_eq("R5 full core alone", 64'(gnt), 64'(32'h1 << 10));
        check_eq("R5 only its bank", 64'(bank_en), 64'b1000);
        @(negedge clk);
        req = '0;

        // R6: full core idle, others use own banks
        wait_slot(2);
        req[2] = 1'b1; req[18] = 1'b1; req[26] = 1'b1;
        #1;
        check_eq("R6 slot passed back", 64'(gnt),
                 64'((32'h1 << 2) | (32'h1 << 18) | (32'h1 << 26)));
        check_eq("R6 local banks", 64'(bank_en), 64'b1101);
        @(negedge clk);
        req = '0;

        // R8: local top address bits ignored
        access(18, mk_addr(1, 9), 1'b1, 32'h0000_1818, 4'b0100);
        access(22, mk_addr(0, 9), 1'b0, 32'h0000_1818, 4'b0100);

        repeat (2) @(negedge clk);
        #1;
        check_eq("R9 rdata zero when idle", 64'(rdata == '0), 64'd1);

        // R4: clear then reassign
        cfg_write(0, 10, 1'b0);
        cfg_write(0, 2, 1'b1);
        #1;
        check_eq("R4 error sticky", 64'(cfg_err), 64'd1);
        access(2, mk_addr(2, 9), 1'b1, 32'h0000_0202, 4'b0100);

        // R2: reset clears marks and error
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check_eq("R2 error cleared", 64'(cfg_err), 64'd0);
        access(2, mk_addr(3, 5), 1'b1, 32'h0000_0505, 4'b0001);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule